// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This unit holds the stack pointer of a small 8-bit processor and turns stack operations into byte accesses on data memory. The stack grows toward lower addresses. The pointer always names the next free location. A one-byte push writes at the pointer and then moves it down by one. A one-byte pop moves the pointer up by one and reads the location it now names. Saving a 16-bit return address takes two back-to-back write cycles and moves the pointer down by two. Restoring one takes two read cycles and moves it up by two.

Software sees the pointer as two 8-bit I/O registers, a high half and a low half. Each half can be read and written on its own. The pointer width is a parameter. Bits above that width read as zero, and writes to them are dropped. After reset the pointer holds the top RAM address. A sticky flag reports any push that takes the pointer below the RAM base address. The unit drives the memory address, the strobes and the write byte. The memory and the program counter sit outside it.

Top module: `stk_ptr_unit`

## Requirements
- R1: After reset the pointer equals RAM_TOP (default 0x4FF), the underflow flag is 0 and busy is 0.
- R2: A byte push strobe writes push_data to address SP in the same cycle, and SP becomes SP-1 after the clock edge.
- R3: A byte pop strobe reads address SP+1 in the same cycle, and SP becomes SP+1 after the clock edge.
- R4: A return push writes ret_addr[7:0] at SP in the strobe cycle. In the following cycle busy is 1 and ret_addr[15:8] is written at SP-1. The net change to SP is -2.
- R5: A return pop reads SP+1 with ret_byte_hi=1 in the strobe cycle. In the following cycle, with busy=1, it reads the next address up with ret_byte_hi=0. The net change to SP is +2.
- R6: I/O address 0x3E reads and writes the pointer's high half, and 0x3D the low half. Any other address reads 0x00, and a write to it has no effect.
- R7: Pointer bits at or above PTR_W (default 11) read as zero on sp_o and io_rdata, and writes to them are discarded.
- R8: A software write to either half takes precedence. A stack strobe in the same cycle is dropped with no memory access. A write during the second cycle of a return push or pop cancels that second access.
- R9: A cycle with more than one strobe, or any strobe while busy is 1, causes no memory access and no pointer change.
- R10: A push whose new pointer would fall below RAM_BASE (default 0x100) sets the underflow flag. For a return push this test is made at the strobe, on SP-2. The flag stays set until a software write to either half clears it.
- R11: Pointer arithmetic wraps modulo 2^PTR_W. A pop at 0x7FF reads address 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_push | input | 1 | Byte push strobe |
| op_pop | input | 1 | Byte pop strobe |
| op_rpush | input | 1 | Return-address push strobe |
| op_rpop | input | 1 | Return-address pop strobe |
| push_data | input | 8 | Byte to store on a byte push |
| ret_addr | input | 16 | Return address to store on a return push |
| io_addr | input | 6 | I/O register address |
| io_we | input | 1 | I/O write enable |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for io_addr (combinational) |
| sp_o | output | 16 | Current pointer, zero-extended |
| mem_addr | output | 16 | Data memory address for this cycle |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| mem_wdata | output | 8 | Byte to write |
| ret_byte_hi | output | 1 | On a return-pop read, 1 when the byte is the high half |
| busy | output | 1 | Second cycle of a return push or pop |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The hardest case to reach from the ports is a collision in the second cycle of a return operation. The second access has no strobe of its own, so a software write or a new strobe has to land exactly one cycle after the return strobe. The stimulus drives these cycles by hand, with no helper task. It places an I/O write, and in a separate run a byte push, in the cycle that follows a return push. The scoreboard then expects only the accesses that should survive. Underflow is reached by writing the pointer to just above the RAM base. The bench then pushes across that boundary, and in a separate run pushes across address zero.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_RPUSH = 3'd3,
    OP_RPOP  = 3'd4
  } stk_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RPUSH = 2'd1,
    SQ_RPOP  = 2'd2
  } stk_seq_e;

  // One step of the pointer: up by one or down by one, on a 16-bit view
  function automatic logic [15:0] sp_step(input logic [15:0] sp, input logic up);
    return up ? (sp + 16'd1) : (sp - 16'd1);
  endfunction

  // True when sp - n would end below base (or wrap past zero)
  function automatic logic sp_below(input logic [15:0] sp, input logic [1:0] n,
                                    input logic [15:0] base);
    return ({1'b0, sp} < ({1'b0, base} + 17'(n)));
  endfunction

  // Merge a software write into the 16-bit view of the pointer
  function automatic logic [15:0] sp_merge(input logic [15:0] sp, input logic wr_hi,
                                           input logic wr_lo, input logic [7:0] wdata);
    return {wr_hi ? wdata : sp[15:8], wr_lo ? wdata : sp[7:0]};
  endfunction

endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode #(
  parameter int unsigned IO_AW   = 6,
  parameter logic [5:0]  HI_ADDR = 6'h3E,
  parameter logic [5:0]  LO_ADDR = 6'h3D
) (
  input  logic              op_push,
  input  logic              op_pop,
  input  logic              op_rpush,
  input  logic              op_rpop,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_we,
  input  logic              busy,
  output stk_pkg::stk_op_e  op_sel,
  output logic              sw_wr_hi,
  output logic              sw_wr_lo,
  output logic              sw_wr,
  output logic              multi_hot
);
  import stk_pkg::*;

  logic [3:0] strb;

  assign strb      = {op_rpop, op_rpush, op_pop, op_push};
  assign multi_hot = (strb & (strb - 4'd1)) != 4'd0;
  assign sw_wr_hi  = io_we && (io_addr == IO_AW'(HI_ADDR));
  assign sw_wr_lo  = io_we && (io_addr == IO_AW'(LO_ADDR));
  assign sw_wr     = sw_wr_hi || sw_wr_lo;

  always_comb begin
    op_sel = OP_NONE;
    if (!multi_hot && !sw_wr && !busy) begin
      case (strb)
        4'b0001: op_sel = OP_PUSH;
        4'b0010: op_sel = OP_POP;
        4'b0100: op_sel = OP_RPUSH;
        4'b1000: op_sel = OP_RPOP;
        default: op_sel = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/stk_ret_seq.sv
module stk_ret_seq (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_pkg::stk_op_e op_sel,
  input  logic             sw_wr,
  input  logic [7:0]       ret_hi,
  output logic             busy,
  output logic             second_wr,
  output logic             second_rd,
  output logic [7:0]       hi_byte
);
  import stk_pkg::*;

  stk_seq_e state_q;
  logic [7:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      hi_q    <= 8'h00;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (op_sel == OP_RPUSH) begin
            state_q <= SQ_RPUSH;
            hi_q    <= ret_hi;
          end else if (op_sel == OP_RPOP) begin
            state_q <= SQ_RPOP;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign second_wr = (state_q == SQ_RPUSH) && !sw_wr;
  assign second_rd = (state_q == SQ_RPOP) && !sw_wr;
  assign hi_byte   = hi_q;

endmodule

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
  parameter int unsigned PTR_W    = 11,
  parameter logic [15:0] RAM_TOP  = 16'h04FF,
  parameter logic [15:0] RAM_BASE = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_hi,
  input  logic             sw_wr_lo,
  input  logic [7:0]       wdata,
  input  logic             step_dn,
  input  logic             step_up,
  input  logic             uf_chk,
  input  logic [1:0]       uf_n,
  output logic [15:0]      sp_ext,
  output logic             underflow
);
  import stk_pkg::*;

  localparam logic [PTR_W-1:0] SP_RST = PTR_W'(RAM_TOP);

  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] sp_d;
  logic             uf_q;
  logic             uf_hit;

  assign sp_ext = 16'(sp_q);
  assign uf_hit = uf_chk && sp_below(sp_ext, uf_n, RAM_BASE);

  always_comb begin
    sp_d = sp_q;
    if (sw_wr_hi || sw_wr_lo)
      sp_d = PTR_W'(sp_merge(sp_ext, sw_wr_hi, sw_wr_lo, wdata));
    else if (step_dn)
      sp_d = PTR_W'(sp_step(sp_ext, 1'b0));
    else if (step_up)
      sp_d = PTR_W'(sp_step(sp_ext, 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_RST;
      uf_q <= 1'b0;
    end else begin
      sp_q <= sp_d;
      if (sw_wr_hi || sw_wr_lo)
        uf_q <= 1'b0;
      else if (uf_hit)
        uf_q <= 1'b1;
    end
  end

  assign underflow = uf_q;

endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit #(
  parameter int unsigned PTR_W    = 11,
  parameter logic [15:0] RAM_TOP  = 16'h04FF,
  parameter logic [15:0] RAM_BASE = 16'h0100,
  parameter int unsigned IO_AW    = 6,
  parameter logic [5:0]  HI_ADDR  = 6'h3E,
  parameter logic [5:0]  LO_ADDR  = 6'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_push,
  input  logic              op_pop,
  input  logic              op_rpush,
  input  logic              op_rpop,
  input  logic [7:0]        push_data,
  input  logic [15:0]       ret_addr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_we,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [15:0]       sp_o,
  output logic [15:0]       mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  output logic              ret_byte_hi,
  output logic              busy,
  output logic              underflow
);
  import stk_pkg::*;

  stk_op_e     op_sel;
  logic        sw_wr_hi;
  logic        sw_wr_lo;
  logic        sw_wr;
  logic        multi_hot;
  logic        second_wr;
  logic        second_rd;
  logic [7:0]  hi_byte;
  logic [15:0] sp_ext;
  logic [15:0] sp_up;
  logic        uf_chk;
  logic [1:0]  uf_n;

  stk_op_decode #(.IO_AW(IO_AW), .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR)) u_dec (
    .op_push   (op_push),
    .op_pop    (op_pop),
    .op_rpush  (op_rpush),
    .op_rpop   (op_rpop),
    .io_addr   (io_addr),
    .io_we     (io_we),
    .busy      (busy),
    .op_sel    (op_sel),
    .sw_wr_hi  (sw_wr_hi),
    .sw_wr_lo  (sw_wr_lo),
    .sw_wr     (sw_wr),
    .multi_hot (multi_hot)
  );

  stk_ret_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .sw_wr     (sw_wr),
    .ret_hi    (ret_addr[15:8]),
    .busy      (busy),
    .second_wr (second_wr),
    .second_rd (second_rd),
    .hi_byte   (hi_byte)
  );

  assign uf_chk = (op_sel == OP_PUSH) || (op_sel == OP_RPUSH);
  assign uf_n   = (op_sel == OP_RPUSH) ? 2'd2 : 2'd1;

  stk_ptr_reg #(.PTR_W(PTR_W), .RAM_TOP(RAM_TOP), .RAM_BASE(RAM_BASE)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_wr_hi  (sw_wr_hi),
    .sw_wr_lo  (sw_wr_lo),
    .wdata     (io_wdata),
    .step_dn   (mem_we),
    .step_up   (mem_re),
    .uf_chk    (uf_chk),
    .uf_n      (uf_n),
    .sp_ext    (sp_ext),
    .underflow (underflow)
  );

  // Address one above the pointer, wrapped to the implemented width
  assign sp_up = 16'(PTR_W'(sp_step(sp_ext, 1'b1)));

  always_comb begin
    mem_we      = 1'b0;
    mem_re      = 1'b0;
    mem_addr    = sp_ext;
    mem_wdata   = 8'h00;
    ret_byte_hi = 1'b0;
    case (op_sel)
      OP_PUSH: begin
        mem_we    = 1'b1;
        mem_wdata = push_data;
      end
      OP_RPUSH: begin
        mem_we    = 1'b1;
        mem_wdata = ret_addr[7:0];
      end
      OP_POP: begin
        mem_re   = 1'b1;
        mem_addr = sp_up;
      end
      OP_RPOP: begin
        mem_re      = 1'b1;
        mem_addr    = sp_up;
        ret_byte_hi = 1'b1;
      end
      default: begin
        if (second_wr) begin
          mem_we    = 1'b1;
          mem_wdata = hi_byte;
        end else if (second_rd) begin
          mem_re   = 1'b1;
          mem_addr = sp_up;
        end
      end
    endcase
  end

  always_comb begin
    if (io_addr == IO_AW'(HI_ADDR))
      io_rdata = sp_ext[15:8];
    else if (io_addr == IO_AW'(LO_ADDR))
      io_rdata = sp_ext[7:0];
    else
      io_rdata = 8'h00;
  end

  assign sp_o = sp_ext;

endmodule

// File: rtl/stk_ptr_chk.sv
module stk_ptr_chk #(
  parameter int unsigned PTR_W   = 11,
  parameter logic [15:0] RAM_TOP = 16'h04FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_pkg::stk_op_e op_sel,
  input  logic             sw_wr,
  input  logic             sw_wr_lo,
  input  logic             multi_hot,
  input  logic [7:0]       io_wdata,
  input  logic [15:0]      sp_o,
  input  logic             mem_we,
  input  logic             mem_re,
  input  logic             busy,
  input  logic             underflow
);
  import stk_pkg::*;

  localparam logic [15:0] MASK = 16'((17'd1 << PTR_W) - 17'd1);

  a_r1_reset_top: assert property (@(posedge clk)
    $rose(rst_n) |-> (sp_o == (RAM_TOP & MASK)) && !busy && !underflow);

  a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_PUSH) |=> sp_o == (($past(sp_o) - 16'd1) & MASK));

  a_r3_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_POP) |=> sp_o == (($past(sp_o) + 16'd1) & MASK));

  a_r4_rpush_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_RPUSH) |=> busy);

  a_r5_rpop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_RPOP) |=> busy);

  a_r6_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_lo |=> sp_o[7:0] == $past(io_wdata));

  a_r8_sw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |-> !mem_we && !mem_re);

  a_r9_multi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hot |-> !mem_we && !mem_re);

  a_r9_busy_no_op: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> op_sel == OP_NONE);

  a_r9_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> !underflow);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !sw_wr) |=> underflow);

endmodule

bind stk_ptr_unit stk_ptr_chk #(.PTR_W(PTR_W), .RAM_TOP(RAM_TOP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_sel    (op_sel),
  .sw_wr     (sw_wr),
  .sw_wr_lo  (sw_wr_lo),
  .multi_hot (multi_hot),
  .io_wdata  (io_wdata),
  .sp_o      (sp_o),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .busy      (busy),
  .underflow (underflow)
);

// File: tb/sim_stk_ptr_unit.sv
module sim_stk_ptr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_push = 1'b0, op_pop = 1'b0, op_rpush = 1'b0, op_rpop = 1'b0;
  logic [7:0]  push_data = 8'h00;
  logic [15:0] ret_addr = 16'h0000;
  logic [5:0]  io_addr = 6'h00;
  logic        io_we = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [15:0] sp_o, mem_addr;
  logic        mem_we, mem_re, ret_byte_hi, busy, underflow;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [7:0]  data;
    bit          hi;
    string       tag;
  } acc_t;
  acc_t exp_q[$];

  always #5 clk = ~clk;

  stk_ptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_push(op_push), .op_pop(op_pop),
    .op_rpush(op_rpush), .op_rpop(op_rpop), .push_data(push_data),
    .ret_addr(ret_addr), .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .sp_o(sp_o), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .ret_byte_hi(ret_byte_hi),
    .busy(busy), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic expect_acc(input bit we, input logic [15:0] a, input logic [7:0] d,
                            input bit hi, input string tag);
    acc_t e;
    e.we = we; e.addr = a; e.data = d; e.hi = hi; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: sample 1 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rst_n && (mem_we || mem_re)) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected access", {15'd0, mem_we, mem_addr}, 32'h0);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk(mem_we == e.we, {e.tag, " kind"}, {31'd0, mem_we}, {31'd0, e.we});
          chk(mem_addr == e.addr, {e.tag, " addr"}, {16'd0, mem_addr}, {16'd0, e.addr});
          if (e.we)
            chk(mem_wdata == e.data, {e.tag, " data"}, {24'd0, mem_wdata}, {24'd0, e.data});
          else
            chk(ret_byte_hi == e.hi, {e.tag, " half"}, {31'd0, ret_byte_hi}, {31'd0, e.hi});
        end
      end
    end
  end

  task automatic cyc(input bit pu, input bit po, input bit rpu, input bit rpo,
                     input logic [7:0] pd, input logic [15:0] ra,
                     input bit we, input logic [5:0] a, input logic [7:0] wd);
    @(negedge clk);
    op_push = pu; op_pop = po; op_rpush = rpu; op_rpop = rpo;
    push_data = pd; ret_addr = ra; io_we = we; io_addr = a; io_wdata = wd;
    @(negedge clk);
    op_push = 0; op_pop = 0; op_rpush = 0; op_rpop = 0; io_we = 0;
  endtask

  task automatic sw_wr(input logic [5:0] a, input logic [7:0] d);
    cyc(0, 0, 0, 0, 8'h00, 16'h0, 1'b1, a, d);
  endtask

  task automatic sp_chk(input logic [15:0] e, input string tag);
    #1;
    chk(sp_o == e, tag, {16'd0, sp_o}, {16'd0, e});
  endtask

  task automatic io_chk(input logic [5:0] a, input logic [7:0] e, input string tag);
    io_addr = a;
    #1;
    chk(io_rdata == e, tag, {24'd0, io_rdata}, {24'd0, e});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    sp_chk(16'h04FF, "R1 reset sp");
    chk(!underflow && !busy, "R1 flags", {30'd0, underflow, busy}, 32'h0);
    io_chk(6'h3E, 8'h04, "R6 read hi");
    io_chk(6'h3D, 8'hFF, "R6 read lo");

    // R2 byte push
    expect_acc(1, 16'h04FF, 8'hA5, 0, "R2 push1");
    cyc(1, 0, 0, 0, 8'hA5, 16'h0, 0, 6'h0, 8'h0);
    sp_chk(16'h04FE, "R2 sp after push1");
    expect_acc(1, 16'h04FE, 8'h3C, 0, "R2 push2");
    cyc(1, 0, 0, 0, 8'h3C, 16'h0, 0, 6'h0, 8'h0);
    sp_chk(16'h04FD, "R2 sp after push2");

    // R3 byte pop
    expect_acc(0, 16'h04FE, 8'h00, 0, "R3 pop1");
    cyc(0, 1, 0, 0, 8'h00, 16'h0, 0, 6'h0, 8'h0);
    sp_chk(16'h04FE, "R3 sp after pop1");
    expect_acc(0, 16'h04FF, 8'h00, 0, "R3 pop2");
    cyc(0, 1, 0, 0, 8'h00, 16'h0, 0, 6'h0, 8'h0);
    sp_chk(16'h04FF, "R3 sp after pop2");

    // R4 return push
    expect_acc(1, 16'h04FF, 8'h34, 0, "R4 low byte");
    expect_acc(1, 16'h04FE, 8'h12, 0, "R4 high byte");
    cyc(0, 0, 1, 0, 8'h00, 16'h1234, 0, 6'h0, 8'h0);
    #1 chk(busy, "R4 busy second cycle", {31'd0, busy}, 32'h1);
    @(negedge clk);
    sp_chk(16'h04FD, "R4 sp net -2");

    // R5 return pop
    expect_acc(0, 16'h04FE, 8'h00, 1, "R5 high read");
    expect_acc(0, 16'h04FF, 8'h00, 0, "R5 low read");
    cyc(0, 0, 0, 1, 8'h00, 16'h0, 0, 6'h0, 8'h0);
    #1 chk(busy, "R5 busy second cycle", {31'd0, busy}, 32'h1);
    @(negedge clk);
    sp_chk(16'h04FF, "R5 sp net +2");

    // R6 software halves
    sw_wr(6'h3E, 8'h02);
    sp_chk(16'h02FF, "R6 write hi");
    sw_wr(6'h3D, 8'h10);
    sp_chk(16'h0210, "R6 write lo");
    io_chk(6'h3E, 8'h02, "R6 readback hi");
    io_chk(6'h3D, 8'h10, "R6 readback lo");

    // R7 unimplemented bits
    sw_wr(6'h3E, 8'hFF);
    sp_chk(16'h0710, "R7 high bits dropped");
    io_chk(6'h3E, 8'h07, "R7 read hi zero-filled");

    // R6 other address ignored
    sw_wr(6'h3F, 8'h55);
    sp_chk(16'h0710, "R6 foreign write ignored");
    io_chk(6'h3F, 8'h00, "R6 foreign read zero");

    // R8 write beats strobe in the same cycle
    cyc(1, 0, 0, 0, 8'h99, 16'h0, 1, 6'h3D, 8'h20);
    sp_chk(16'h0720, "R8 write wins over push");

    // R8 write cancels second step of return push
    sw_wr(6'h3E, 8'h03);
    sw_wr(6'h3D, 8'h00);
    expect_acc(1, 16'h0300, 8'hEF, 0, "R8 first byte kept");
    @(negedge clk);
    op_rpush = 1; ret_addr = 16'hBEEF;
    @(negedge clk);
    op_rpush = 0; io_we = 1; io_addr = 6'h3D; io_wdata = 8'h40;
    @(negedge clk);
    io_we = 0;
    sp_chk(16'h0240, "R8 cancelled second step");

    // R9 two strobes at once
    cyc(1, 1, 0, 0, 8'h11, 16'h0, 0, 6'h0, 8'h0);
    sp_chk(16'h0240, "R9 multi strobe ignored");

    // R9 strobe while busy
    expect_acc(1, 16'h0240, 8'h57, 0, "R9 rpush low");
    expect_acc(1, 16'h023F, 8'h13, 0, "R9 rpush high");
    @(negedge clk);
    op_rpush = 1; ret_addr = 16'h1357;
    @(negedge clk);
    op_rpush = 0; op_push = 1; push_data = 8'h77;
    @(negedge clk);
    op_push = 0;
    sp_chk(16'h023E, "R9 push during busy ignored");

    // R10 underflow
    sw_wr(6'h3E, 8'h01);
    sw_wr(6'h3D, 8'h01);
    expect_acc(1, 16'h0101, 8'h01, 0, "R10 push at base+1");
    cyc(1, 0, 0, 0, 8'h01, 16'h0, 0, 6'h0, 8'h0);
    #1 chk(!underflow, "R10 no flag at base", {31'd0, underflow}, 32'h0);
    expect_acc(1, 16'h0100, 8'h02, 0, "R10 push below base");
    cyc(1, 0, 0, 0, 8'h02, 16'h0, 0, 6'h0, 8'h0);
    #1 chk(underflow, "R10 flag set", {31'd0, underflow}, 32'h1);
    @(negedge clk);
    #1 chk(underflow, "R10 flag sticky", {31'd0, underflow}, 32'h1);
    sw_wr(6'h3D, 8'h01);
    #1 chk(!underflow, "R10 cleared by write", {31'd0, underflow}, 32'h0);
    sw_wr(6'h3E, 8'h01);
    expect_acc(1, 16'h0101, 8'hFE, 0, "R10 rpush low");
    expect_acc(1, 16'h0100, 8'hCA, 0, "R10 rpush high");
    cyc(0, 0, 1, 0, 8'h00, 16'hCAFE, 0, 6'h0, 8'h0);
    #1 chk(underflow, "R10 rpush flag", {31'd0, underflow}, 32'h1);
    @(negedge clk);
    sp_chk(16'h00FF, "R10 sp after rpush");

    // R11 wrap
    sw_wr(6'h3E, 8'h07);
    sw_wr(6'h3D, 8'hFF);
    expect_acc(0, 16'h0000, 8'h00, 0, "R11 pop wraps");
    cyc(0, 1, 0, 0, 8'h00, 16'h0, 0, 6'h0, 8'h0);
    sp_chk(16'h0000, "R11 sp wrapped up");
    expect_acc(1, 16'h0000, 8'h66, 0, "R11 push at zero");
    cyc(1, 0, 0, 0, 8'h66, 16'h0, 0, 6'h0, 8'h0);
    sp_chk(16'h07FF, "R11 sp wrapped down");
    chk(underflow, "R10 flag on wrap", {31'd0, underflow}, 32'h1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all expected accesses seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule